// File: doc/BRIEF.md
# Paged Opcode Instruction Framer

This block sits between an instruction fetch unit and a decoder for an 8-bit CPU whose opcode space is split into three pages. Code bytes arrive one at a time over a valid/ready interface. The framer decides from the first byte whether an escape prefix selects one of the two extension pages. It then reads the opcode byte and looks up how many operand bytes that opcode carries on its page, which can be zero, one or two. When the instruction is complete, it presents the whole instruction as one record. The record holds up to four bytes, the length, the page tag, an undefined-opcode flag, and the first operand byte plus the two operand bytes joined into a 16-bit value.

Any 16-bit operand arrives low byte first. The framer joins the two operand bytes so the second byte becomes the upper half. An opcode slot with no defined meaning is flagged. It is closed after its opcode byte, so the byte stream stays aligned for the next instruction. While a finished record waits for the consumer, no new byte is taken.

The control is one state machine with four states. `ST_OPCODE` waits for the first byte of an instruction. `ST_PAGED` waits for the opcode byte after a prefix. `ST_OPERAND` collects the remaining operand bytes. `ST_HOLD` presents the record.

The transitions are:
- `ST_OPCODE` goes to `ST_PAGED` on a prefix byte.
- `ST_OPCODE` and `ST_PAGED` go to `ST_HOLD` when the opcode needs no operand.
- `ST_OPCODE` and `ST_PAGED` go to `ST_OPERAND` when the opcode needs one or two operands.
- `ST_OPERAND` goes to `ST_HOLD` on the last operand byte.
- `ST_HOLD` goes to `ST_OPCODE` when the record is accepted.
- Synchronous reset forces `ST_OPCODE` from any state.

Top module: `instr_framer`

## Requirements
- R1: A first byte of 0xCE gives page tag 1, and a first byte of 0xCF gives page tag 2. The opcode is then the next byte, and the prefix counts in the length. Any other first byte is itself a page-0 opcode.
- R2: On page 0, the length (`out_len`) is 1 plus the operand count. Two operands: 0x05, 0x0D, 0x15, 0x1D, 0x25, 0x2D, 0x35, 0x3D, 0xB8-0xBF, 0xC0-0xC7, 0xD0-0xDD, 0xE8-0xEF, 0xF2, 0xF3 and 0xFB. One operand: 0x00-0x3F with low three bits 2 or 4, 0x40-0x77 with low three bits 4, 0x78-0x7E, 0x85, 0x8D, 0x95-0x97, 0x9C-0x9F, 0xB0-0xB7, 0xE0-0xE7, 0xF0, 0xF1, 0xF5, 0xFC and 0xFD. Every other defined opcode has no operand.
- R3: On page 1, the length is 2 plus the operand count. Two operands: 0xD0-0xD7. One operand: 0x00-0x3F with low three bits 0, 1 or 5; 0x40-0x73 with low two bits 0 or 1; 0x80-0xA7 with low two bits 2; 0xB0-0xBC; 0xC4-0xC7; and 0xE0-0xFF. Every other defined opcode has no operand.
- R4: On page 2, the length is 2 plus the operand count. Two operands: 0x60-0x67, 0x78 and 0x79. One operand: 0x70-0x77. Every other defined opcode has no operand.
- R5: Some opcodes are undefined. On page 0: 0x7F and 0xFF. On page 1: 0x68-0x6F, 0x74-0x7F, 0xAB-0xAF, 0xBD-0xBF and 0xDA-0xDF. On page 2: 0x14-0x1F, 0x34-0x3F, 0x4C-0x4F, 0x52-0x5F, 0x68-0x6F, 0x7A-0xAF, 0xBC-0xBF, 0xC8-0xCF and 0xFA-0xFF. An undefined opcode sets `out_illegal`, and its record ends at the opcode byte (length 1 on page 0, 2 on pages 1 and 2).
- R6: `out_bytes` holds the k-th accepted byte of the instruction in bits [8k+7:8k], counting from k=0. Bytes beyond the length read as zero.
- R7: `out_imm8` is the first operand byte. `out_imm16` has the first operand byte in bits [7:0] and the second in bits [15:8]. A field with no operand byte behind it reads zero.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the record holds every field unchanged.
- R9: `out_valid` rises in the cycle after the clock edge that accepts the last byte of an instruction. It falls after the edge where `out_ready` is high. At all other times `in_ready` is high.
- R10: A synchronous reset drops any partly collected instruction. After reset, `out_valid` is low, `in_ready` is high, and the next byte is treated as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A code byte is offered |
| in_data | input | 8 | Offered code byte |
| in_ready | output | 1 | Framer takes the offered byte at this edge |
| out_valid | output | 1 | A complete instruction record is presented |
| out_ready | input | 1 | Consumer takes the record at this edge |
| out_bytes | output | 32 | Instruction bytes, first byte in the low lane |
| out_len | output | 3 | Instruction length in bytes, 1 to 4 |
| out_page | output | 2 | Opcode page tag, 0 to 2 |
| out_illegal | output | 1 | Opcode slot has no defined meaning |
| out_imm8 | output | 8 | First operand byte |
| out_imm16 | output | 16 | Operand bytes joined, second byte high |

## Verification
A wrong operand count or a lost prefix does not stay inside one record. It shifts every later record, so the mismatch usually shows within a record or two. It then keeps showing as wrong lengths, page tags and undefined flags on later records. A byte counter or operand counter that slips shows at once as a wrong length or a zero in the wrong byte lane. A state that leaves `ST_HOLD` too early or too late shows in the same cycle as a disagreement between `out_valid`, `in_ready` and the record count predicted by a behavioural model that is compared every clock. The reset case feeds a deliberately unfinished instruction before the reset, so a leftover partial frame would corrupt the very next record.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int ARG_W     = 2;

    typedef enum logic [1:0] {
        PG_BASE = 2'd0,
        PG_EXT1 = 2'd1,
        PG_EXT2 = 2'd2
    } page_e;

    typedef enum logic [1:0] {
        ST_OPCODE  = 2'd0,
        ST_PAGED   = 2'd1,
        ST_OPERAND = 2'd2,
        ST_HOLD    = 2'd3
    } state_e;
endpackage

// File: rtl/frm_len_decode.sv
module frm_len_decode
    import frm_pkg::*;
(
    input  page_e                   page,
    input  logic [BYTE_W-1:0]       opcode,
    output logic [ARG_W-1:0]        n_args,
    output logic                    undef
);
    logic [3:0] hi;
    logic [3:0] nib;
    logic [2:0] lo;

    assign hi  = opcode[7:4];
    assign nib = opcode[3:0];
    assign lo  = opcode[2:0];

    always_comb begin
        n_args = '0;
        undef  = 1'b0;
        unique case (page)
            PG_BASE: begin
                unique case (hi)
                    4'h0, 4'h1, 4'h2, 4'h3:
                        n_args = (lo == 3'd5) ? 2'd2 :
                                 ((lo == 3'd2 || lo == 3'd4) ? 2'd1 : 2'd0);
                    4'h4, 4'h5, 4'h6: n_args = (lo == 3'd4) ? 2'd1 : 2'd0;
                    4'h7: begin
                        if (nib == 4'hF) undef = 1'b1;
                        else n_args = (nib[3] || lo == 3'd4) ? 2'd1 : 2'd0;
                    end
                    4'h8: n_args = (lo == 3'd5) ? 2'd1 : 2'd0;
                    4'h9: n_args = (nib >= 4'hC || (nib >= 4'h5 && nib <= 4'h7)) ? 2'd1 : 2'd0;
                    4'hA: n_args = 2'd0;
                    4'hB: n_args = nib[3] ? 2'd2 : 2'd1;
                    4'hC: n_args = nib[3] ? 2'd0 : 2'd2;
                    4'hD: n_args = (nib < 4'hE) ? 2'd2 : 2'd0;
                    4'hE: n_args = nib[3] ? 2'd2 : 2'd1;
                    default: begin
                        unique case (nib)
                            4'h0, 4'h1, 4'h5, 4'hC, 4'hD: n_args = 2'd1;
                            4'h2, 4'h3, 4'hB:             n_args = 2'd2;
                            4'hF:                         undef  = 1'b1;
                            default:                      n_args = 2'd0;
                        endcase
                    end
                endcase
            end
            PG_EXT1: begin
                unique case (hi)
                    4'h0, 4'h1, 4'h2, 4'h3:
                        n_args = (lo == 3'd0 || lo == 3'd1 || lo == 3'd5) ? 2'd1 : 2'd0;
                    4'h4, 4'h5: n_args = nib[1] ? 2'd0 : 2'd1;
                    4'h6: begin
                        if (nib[3]) undef = 1'b1;
                        else n_args = nib[1] ? 2'd0 : 2'd1;
                    end
                    4'h7: begin
                        if (nib >= 4'h4) undef = 1'b1;
                        else n_args = nib[1] ? 2'd0 : 2'd1;
                    end
                    4'h8, 4'h9: n_args = (nib[1:0] == 2'd2) ? 2'd1 : 2'd0;
                    4'hA: begin
                        if (nib > 4'hA) undef = 1'b1;
                        else if (!nib[3]) n_args = (nib[1:0] == 2'd2) ? 2'd1 : 2'd0;
                    end
                    4'hB: begin
                        if (nib > 4'hC) undef = 1'b1;
                        else n_args = 2'd1;
                    end
                    4'hC: n_args = (nib[3:2] == 2'b01) ? 2'd1 : 2'd0;
                    4'hD: begin
                        if (nib > 4'h9) undef = 1'b1;
                        else n_args = nib[3] ? 2'd0 : 2'd2;
                    end
                    default: n_args = 2'd1;
                endcase
            end
            PG_EXT2: begin
                unique case (hi)
                    4'h1, 4'h3: undef = (nib >= 4'h4);
                    4'h4:       undef = (nib >= 4'hC);
                    4'h5:       undef = (nib >= 4'h2);
                    4'h6: begin
                        if (nib[3]) undef = 1'b1;
                        else n_args = 2'd2;
                    end
                    4'h7: begin
                        if (nib > 4'h9) undef = 1'b1;
                        else n_args = nib[3] ? 2'd2 : 2'd1;
                    end
                    4'h8, 4'h9, 4'hA: undef = 1'b1;
                    4'hB:       undef = (nib >= 4'hC);
                    4'hC:       undef = nib[3];
                    4'hF:       undef = (nib >= 4'hA);
                    default:    n_args = 2'd0;
                endcase
            end
            default: undef = 1'b1;
        endcase
    end
endmodule

// File: rtl/frm_collect.sv
module frm_collect
    import frm_pkg::*;
#(
    parameter int NB = MAX_BYTES,
    parameter int IW = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_first,
    input  logic [IW-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic                 paged,
    output logic [NB*BYTE_W-1:0] bytes,
    output logic [BYTE_W-1:0]    imm8,
    output logic [2*BYTE_W-1:0]  imm16
);
    logic [BYTE_W-1:0] lane [NB];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane[i] <= '0;
            end else if (wr_en) begin
                if (wr_first)
                    lane[i] <= (i == 0) ? wr_byte : '0;
                else if (wr_idx == IW'(i))
                    lane[i] <= wr_byte;
            end
        end
        assign bytes[i*BYTE_W +: BYTE_W] = lane[i];
    end

    // Operands start right after the opcode, one lane later when a prefix is present.
    always_comb begin
        if (paged) begin
            imm8  = lane[2];
            imm16 = {lane[3], lane[2]};
        end else begin
            imm8  = lane[1];
            imm16 = {lane[2], lane[1]};
        end
    end
endmodule

// File: rtl/instr_framer.sv
module instr_framer
    import frm_pkg::*;
#(
    parameter logic [7:0] PFX_A = 8'hCE,
    parameter logic [7:0] PFX_B = 8'hCF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    output logic                        in_ready,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [MAX_BYTES*BYTE_W-1:0] out_bytes,
    output logic [LEN_W-1:0]            out_len,
    output logic [1:0]                  out_page,
    output logic                        out_illegal,
    output logic [7:0]                  out_imm8,
    output logic [15:0]                 out_imm16
);
    state_e            st, st_nx;
    page_e             pg_q, dec_pg;
    logic [LEN_W-1:0]  cnt_q;
    logic [ARG_W-1:0]  left_q;
    logic              ill_q;
    logic [ARG_W-1:0]  dec_n;
    logic              dec_ill;
    logic              take, is_pfx;
    logic [IDX_W-1:0]  wr_idx;

    assign take   = in_valid && in_ready;
    assign is_pfx = (in_data == PFX_A) || (in_data == PFX_B);
    assign dec_pg = (st == ST_PAGED) ? pg_q : PG_BASE;
    assign wr_idx = (st == ST_OPCODE) ? '0 : cnt_q[IDX_W-1:0];

    frm_len_decode u_dec (
        .page   (dec_pg),
        .opcode (in_data),
        .n_args (dec_n),
        .undef  (dec_ill)
    );

    frm_collect #(.NB(MAX_BYTES), .IW(IDX_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (take),
        .wr_first (st == ST_OPCODE),
        .wr_idx   (wr_idx),
        .wr_byte  (in_data),
        .paged    (pg_q != PG_BASE),
        .bytes    (out_bytes),
        .imm8     (out_imm8),
        .imm16    (out_imm16)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_OPCODE;
        else     st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OPCODE: if (in_valid) begin
                if (is_pfx)           st_nx = ST_PAGED;
                else if (dec_n == '0) st_nx = ST_HOLD;
                else                  st_nx = ST_OPERAND;
            end
            ST_PAGED: if (in_valid)
                st_nx = (dec_n == '0) ? ST_HOLD : ST_OPERAND;
            ST_OPERAND: if (in_valid && left_q == ARG_W'(1))
                st_nx = ST_HOLD;
            ST_HOLD: if (out_ready)
                st_nx = ST_OPCODE;
            default: st_nx = ST_OPCODE;
        endcase
    end

    // Frame bookkeeping: page, count, remaining operands, undefined flag
    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q   <= PG_BASE;
            cnt_q  <= '0;
            left_q <= '0;
            ill_q  <= 1'b0;
        end else if (take) begin
            cnt_q <= (st == ST_OPCODE) ? LEN_W'(1) : cnt_q + LEN_W'(1);
            unique case (st)
                ST_OPCODE: begin
                    pg_q   <= (in_data == PFX_A) ? PG_EXT1 :
                              ((in_data == PFX_B) ? PG_EXT2 : PG_BASE);
                    ill_q  <= is_pfx ? 1'b0 : dec_ill;
                    left_q <= is_pfx ? '0 : dec_n;
                end
                ST_PAGED: begin
                    ill_q  <= dec_ill;
                    left_q <= dec_n;
                end
                ST_OPERAND: left_q <= left_q - ARG_W'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_valid   = (st == ST_HOLD);
        in_ready    = (st != ST_HOLD);
        out_len     = cnt_q;
        out_page    = pg_q;
        out_illegal = ill_q;
    end

    a_r8_hold_record: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bytes) &&
                                       $stable(out_len) && $stable(out_page) &&
                                       $stable(out_illegal)));

    a_r1_prefix_lane: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_page == 2'd1) |-> (out_bytes[7:0] == PFX_A));

    a_r5_undef_short: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |->
            (out_len == ((out_page == 2'd0) ? LEN_W'(1) : LEN_W'(2))));

    a_r6_len_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_BYTES)));

    a_r2_base_max: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_page == 2'd0) |-> (out_len <= LEN_W'(3)));

    a_r7_no_operand: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == ((out_page == 2'd0) ? LEN_W'(1) : LEN_W'(2)))
            |-> (out_imm8 == 8'h00 && out_imm16 == 16'h0000));
endmodule

// File: tb/instr_framer_test.sv
module instr_framer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_bytes;
    logic [2:0]  out_len;
    logic [1:0]  out_page;
    logic        out_illegal;
    logic [7:0]  out_imm8;
    logic [15:0] out_imm16;

    typedef struct {
        logic [31:0] bytes;
        int          len;
        int          page;
        bit          ill;
        logic [7:0]  imm8;
        logic [15:0] imm16;
    } rec_t;

    int checks = 0;
    int errors = 0;
    logic [7:0] src_q[$];
    logic [7:0] cur[$];
    rec_t       exp_q[$];
    int         m_need;
    bit         m_bad;

    always #10 clk = ~clk;

    instr_framer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_bytes(out_bytes), .out_len(out_len), .out_page(out_page),
        .out_illegal(out_illegal), .out_imm8(out_imm8), .out_imm16(out_imm16)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Behavioural shape table: operand count and undefined flag per page
    function automatic void ref_shape(input int pg, input int op, output int n, output bit bad);
        n = 0; bad = 0;
        if (pg == 0) begin
            if (op inside {8'h7F, 8'hFF}) bad = 1;
            else if (op < 8'h40) n = (op % 8 == 5) ? 2 : ((op % 8 == 2 || op % 8 == 4) ? 1 : 0);
            else if (op < 8'h78) n = (op % 8 == 4) ? 1 : 0;
            else if (op < 8'h7F) n = 1;
            else if (op inside {8'h85, 8'h8D, [8'h95:8'h97], [8'h9C:8'h9F], [8'hB0:8'hB7],
                                [8'hE0:8'hE7], 8'hF0, 8'hF1, 8'hF5, 8'hFC, 8'hFD}) n = 1;
            else if (op inside {[8'hB8:8'hC7], [8'hD0:8'hDD], [8'hE8:8'hEF],
                                8'hF2, 8'hF3, 8'hFB}) n = 2;
        end else if (pg == 1) begin
            if (op inside {[8'h68:8'h6F], [8'h74:8'h7F], [8'hAB:8'hAF],
                           [8'hBD:8'hBF], [8'hDA:8'hDF]}) bad = 1;
            else if (op < 8'h40) n = (op % 8 inside {0, 1, 5}) ? 1 : 0;
            else if (op < 8'h80) n = (op % 4 < 2) ? 1 : 0;
            else if (op < 8'hA8) n = (op % 4 == 2) ? 1 : 0;
            else if (op inside {[8'hB0:8'hBC], [8'hC4:8'hC7], [8'hE0:8'hFF]}) n = 1;
            else if (op inside {[8'hD0:8'hD7]}) n = 2;
        end else begin
            if (op inside {[8'h14:8'h1F], [8'h34:8'h3F], [8'h4C:8'h4F], [8'h52:8'h5F],
                           [8'h68:8'h6F], [8'h7A:8'hAF], [8'hBC:8'hBF], [8'hC8:8'hCF],
                           [8'hFA:8'hFF]}) bad = 1;
            else if (op inside {[8'h60:8'h67], 8'h78, 8'h79}) n = 2;
            else if (op inside {[8'h70:8'h77]}) n = 1;
        end
    endfunction

    task automatic feed(input logic [7:0] b);
        int pg, opi;
        rec_t r;
        cur.push_back(b);
        if (cur.size() == 1 && (b == 8'hCE || b == 8'hCF)) return;
        pg  = (cur[0] == 8'hCE) ? 1 : ((cur[0] == 8'hCF) ? 2 : 0);
        opi = (pg != 0) ? 1 : 0;
        if (cur.size() == opi + 1) ref_shape(pg, int'(b), m_need, m_bad);
        if (cur.size() == opi + 1 + m_need) begin
            r.bytes = '0;
            foreach (cur[k]) r.bytes[k*8 +: 8] = cur[k];
            r.len   = cur.size();
            r.page  = pg;
            r.ill   = m_bad;
            r.imm8  = (m_need >= 1) ? cur[opi+1] : 8'h00;
            r.imm16 = {(m_need == 2) ? cur[opi+2] : 8'h00, r.imm8};
            exp_q.push_back(r);
            cur.delete();
        end
    endtask

    task automatic compare();
        rec_t e;
        string ltag;
        chk(out_valid == (exp_q.size() > 0), "R9", "out_valid vs pending", 32'(out_valid), 32'(exp_q.size() > 0));
        if (out_valid) chk(!in_ready, "R8", "in_ready while held", 32'(in_ready), 32'd0);
        else           chk(in_ready, "R9", "in_ready while idle", 32'(in_ready), 32'd1);
        if (out_valid && exp_q.size() > 0) begin
            e = exp_q[0];
            ltag = (e.page == 0) ? "R2" : ((e.page == 1) ? "R3" : "R4");
            chk(int'(out_page) == e.page, "R1", "page", 32'(out_page), 32'(e.page));
            chk(int'(out_len) == e.len, ltag, "length", 32'(out_len), 32'(e.len));
            chk(out_illegal == e.ill, "R5", "undefined flag", 32'(out_illegal), 32'(e.ill));
            chk(out_bytes == e.bytes, "R6", "bytes", out_bytes, e.bytes);
            chk({out_imm16, out_imm8} == {e.imm16, e.imm8}, "R7", "operands",
                {8'h00, out_imm16, out_imm8}, {8'h00, e.imm16, e.imm8});
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        in_valid  = (src_q.size() > 0) && ($urandom % 4 != 0);
        in_data   = (src_q.size() > 0) ? src_q[0] : 8'h00;
        out_ready = ($urandom % 3 != 0);
        if (out_valid && out_ready) void'(exp_q.pop_front());
        if (in_valid && in_ready) feed(src_q.pop_front());
    endtask

    task automatic drain();
        while (src_q.size() > 0 || exp_q.size() > 0) step();
    endtask

    task automatic push(input logic [7:0] b[]);
        foreach (b[k]) src_q.push_back(b[k]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cur.delete(); exp_q.delete();
        chk(!out_valid && in_ready, "R10", "state after reset",
            {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
        chk(in_ready, "R10", "in_ready in reset", 32'(in_ready), 32'd1);
        rst = 1'b0;

        // Directed shapes on all three pages, including undefined slots
        push('{8'h10, 8'h13, 8'h12, 8'h55, 8'h14, 8'h66, 8'h15, 8'h34, 8'h12});
        push('{8'hC0, 8'hCD, 8'hAB, 8'hD7, 8'h01, 8'h02, 8'hE8, 8'h00, 8'h01});
        push('{8'hE0, 8'hFE, 8'hF5, 8'h03, 8'hF3, 8'h10, 8'h20, 8'h7F, 8'hFF});
        push('{8'hCE, 8'h10, 8'h7F, 8'hCE, 8'h12, 8'hCE, 8'h88, 8'hCE, 8'h89});
        push('{8'hCE, 8'h8A, 8'h20, 8'hCE, 8'hA0, 8'hCE, 8'hA2, 8'h09, 8'hCE, 8'hA6, 8'h0A});
        push('{8'hCE, 8'hA5, 8'hCE, 8'hD3, 8'h44, 8'h55, 8'hCE, 8'h68, 8'hCE, 8'hCE});
        push('{8'hCF, 8'h78, 8'hAA, 8'hBB, 8'hCF, 8'h79, 8'h11, 8'h22, 8'hCF, 8'h70, 8'h05});
        push('{8'hCF, 8'h77, 8'h06, 8'hCF, 8'h14, 8'hCF, 8'hCE, 8'hCF, 8'h62, 8'h01, 8'h80});
        drain();

        // Random stream
        for (int i = 0; i < 3000; i++) src_q.push_back(8'($urandom));
        drain();

        // Reset in the middle of an instruction
        do_reset();
        push('{8'hCE, 8'h10});
        while (src_q.size() > 0) step();
        repeat (2) step();
        do_reset();
        push('{8'h10, 8'hCF, 8'h79, 8'h34, 8'h12});
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule